// File: doc/BRIEF.md
# Register Bank Prefix Decoder

This block sits in an instruction decoder in front of a legacy two-operand instruction format whose register fields are only 3 bits wide. A special 16-bit prefix word, recognised by a fixed tag in its upper byte, carries extra bank bits. The decoder stores those bits and applies them to the next instruction word only. It turns each 3-bit operand field into a 5-bit index, which covers four banks of eight registers (32 data or floating-point registers). The prefix can also name a destination register other than the usual one, so a two-operand instruction can act as a three-operand one.

When the following instruction uses an effective-address operand, the extension is split in two. One bit selects the base register from sixteen address registers. The other bit extends the index register, which is chosen from sixteen address and sixteen data registers. Without a pending prefix every extension bit is zero, so legacy code decodes exactly as before.

The decoder looks only at the stream of instruction words and at the operand fields that the main decoder has already extracted. Opcode decode, pipelining and memory access belong to other blocks.

Top module: `bank_prefix_decoder`

## Requirements
- R1: A word presented with `iw_valid` high is a prefix when bits 15..8 equal 0x71. For a prefix, `insn_valid` stays low. Any other valid word raises `insn_valid` in the same cycle.
- R2: For the instruction after a prefix, `ext_a` equals {prefix bits 3..2, `op_a_field`}.
- R3: For the instruction after a prefix, `ext_b` equals {prefix bits 1..0, `op_b_field`}.
- R4: A prefix applies to exactly one later valid instruction. Idle cycles with `iw_valid` low do not consume it. The instruction after the extended one decodes with zero extension bits.
- R5: With no prefix pending, `ext_a` and `ext_b` have zero in bits 4..3, and `dst_override` is low.
- R6: A prefix that follows another prefix replaces the stored bank bits completely.
- R7: When prefix bits 5..4 equal 01, `dst_override` is high and `ext_dst` equals {prefix bits 7..6, `op_a_field`}.
- R8: When prefix bits 5..4 equal 10, `dst_override` is high and `ext_dst` equals {prefix bits 7..6, `op_b_field`}.
- R9: When prefix bits 5..4 equal 00 or 11, or no prefix is pending, `dst_override` is low and `ext_dst` equals `ext_b`.
- R10: With `ea_mode` high, `ea_base` equals {prefix bit 2, `op_a_field`} and `ea_index` equals {prefix bit 3, `idx_is_addr`, `op_b_field`}. Index bit 3 is 1 for an address register. With `ea_mode` low, both outputs are zero.
- R11: A synchronous active-low reset discards any pending prefix.
- R12: A word with `iw_valid` low, including one that carries the prefix tag, does not change the stored state.
- R13: Prefix 0x7106 followed by an instruction with `op_a_field`=0 and `op_b_field`=1 gives `ext_a`=8 (bank 1, register 0) and `ext_b`=17 (bank 2, register 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iw_valid | input | 1 | Instruction word strobe |
| iw_data | input | 16 | Instruction word |
| op_a_field | input | 3 | Operand A register field of the current word |
| op_b_field | input | 3 | Operand B register field of the current word |
| ea_mode | input | 1 | Current instruction uses an effective-address operand |
| idx_is_addr | input | 1 | The EA index register is an address register |
| insn_valid | output | 1 | Valid non-prefix instruction this cycle |
| ext_a | output | 5 | Extended operand A index |
| ext_b | output | 5 | Extended operand B index |
| ext_dst | output | 5 | Extended destination index |
| dst_override | output | 1 | Destination taken from the prefix |
| ea_base | output | 4 | EA base register among 16 address registers |
| ea_index | output | 5 | EA index register among 32 candidates |

## Verification
The assertions assume the operand fields and mode flags describe the word currently on `iw_data`. They also assume `iw_valid` stays low while reset is asserted. The stimulus drives all inputs together on the falling edge and holds `iw_valid` low throughout reset. The stimulus covers every destination selector code, both EA bank bits, back-to-back prefixes, idle gaps, and prefixes that are masked by a low strobe or cancelled by reset.

// File: rtl/bankpfx_pkg.sv
// Package: shared constants and the layout of the prefix low byte.
// Assumes a 16-bit instruction word whose upper byte holds the prefix tag.
package bankpfx_pkg;
    localparam int BANK_W = 2;
    localparam int FIELD_W = 3;
    localparam int WORD_W = 16;
    localparam logic [7:0] PREFIX_TAG = 8'h71;

    // Bank selection byte; field order matches bit positions 7..0.
    typedef struct packed {
        logic [BANK_W-1:0] dst_bank;   // bits 7..6
        logic [BANK_W-1:0] dst_mode;   // bits 5..4
        logic [BANK_W-1:0] a_bank;     // bits 3..2
        logic [BANK_W-1:0] b_bank;     // bits 1..0
    } bank_sel_t;
endpackage

// File: rtl/bankpfx_capture.sv
// Module: recognises prefix words and holds their bank byte until one
// instruction has consumed it. Assumes iw_valid qualifies iw_data.
module bankpfx_capture
    import bankpfx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iw_valid,
    input  logic [WORD_W-1:0] iw_data,
    output logic              insn_valid,
    output bank_sel_t         sel_eff
);
    logic      is_prefix;
    logic      pending;
    bank_sel_t sel_q;

    // Classify the incoming word.
    always_comb begin
        is_prefix  = iw_valid && (iw_data[WORD_W-1:WORD_W-8] == PREFIX_TAG);
        insn_valid = iw_valid && !is_prefix;
    end

    // Store a prefix, and clear it once an instruction has used it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            sel_q   <= '0;
        end else if (is_prefix) begin
            pending <= 1'b1;
            sel_q   <= bank_sel_t'(iw_data[7:0]);
        end else if (iw_valid) begin
            pending <= 1'b0;
        end
    end

    // Present zero bank bits unless a prefix is pending.
    always_comb begin
        sel_eff = pending ? sel_q : '0;
    end
endmodule

// File: rtl/bankpfx_extend.sv
// Module: widens a register field with its bank bits.
// Assumes the bank bits are already zero when no prefix applies.
module bankpfx_extend #(
    parameter int BANK_W  = 2,
    parameter int FIELD_W = 3,
    localparam int IDX_W  = BANK_W + FIELD_W
) (
    input  logic [BANK_W-1:0]  bank,
    input  logic [FIELD_W-1:0] field,
    output logic [IDX_W-1:0]   idx
);
    // Concatenate the bank as the upper bits of the index.
    always_comb begin
        idx = {bank, field};
    end
endmodule

// File: rtl/bankpfx_dest.sv
// Module: chooses the destination index from the mode bits of the prefix.
// Assumes the legacy destination is operand B.
module bankpfx_dest #(
    parameter int BANK_W  = 2,
    parameter int FIELD_W = 3,
    localparam int IDX_W  = BANK_W + FIELD_W
) (
    input  logic [BANK_W-1:0]  dst_bank,
    input  logic [BANK_W-1:0]  dst_mode,
    input  logic [FIELD_W-1:0] field_a,
    input  logic [FIELD_W-1:0] field_b,
    input  logic [IDX_W-1:0]   ext_b,
    output logic [IDX_W-1:0]   ext_dst,
    output logic               override
);
    // Select the destination source; codes 00 and 11 keep the legacy destination.
    always_comb begin
        override = 1'b0;
        ext_dst  = ext_b;
        case (dst_mode)
            2'b01: begin
                override = 1'b1;
                ext_dst  = {dst_bank, field_a};
            end
            2'b10: begin
                override = 1'b1;
                ext_dst  = {dst_bank, field_b};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bankpfx_ea.sv
// Module: forms EA base and index selections from single bank bits.
// Assumes op_a carries the base field and op_b the index field in EA mode.
module bankpfx_ea #(
    parameter int FIELD_W = 3
) (
    input  logic               ea_mode,
    input  logic               base_hi,
    input  logic               index_hi,
    input  logic               idx_is_addr,
    input  logic [FIELD_W-1:0] field_a,
    input  logic [FIELD_W-1:0] field_b,
    output logic [FIELD_W:0]   ea_base,
    output logic [FIELD_W+1:0] ea_index
);
    // Build both selections, or zero when no EA operand is present.
    always_comb begin
        if (ea_mode) begin
            ea_base  = {base_hi, field_a};
            ea_index = {index_hi, idx_is_addr, field_b};
        end else begin
            ea_base  = '0;
            ea_index = '0;
        end
    end
endmodule

// File: rtl/bank_prefix_decoder.sv
// Module: top of the bank prefix decoder. It captures the prefix, extends
// both operands, selects the destination and forms the EA selections.
// Assumes the operand fields belong to the word currently on iw_data.
module bank_prefix_decoder
    import bankpfx_pkg::*;
#(
    localparam int IDX_W = BANK_W + FIELD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               iw_valid,
    input  logic [WORD_W-1:0]  iw_data,
    input  logic [FIELD_W-1:0] op_a_field,
    input  logic [FIELD_W-1:0] op_b_field,
    input  logic               ea_mode,
    input  logic               idx_is_addr,
    output logic               insn_valid,
    output logic [IDX_W-1:0]   ext_a,
    output logic [IDX_W-1:0]   ext_b,
    output logic [IDX_W-1:0]   ext_dst,
    output logic               dst_override,
    output logic [FIELD_W:0]   ea_base,
    output logic [FIELD_W+1:0] ea_index
);
    bank_sel_t sel;
    logic [1:0][BANK_W-1:0]  op_bank;
    logic [1:0][FIELD_W-1:0] op_field;
    logic [1:0][IDX_W-1:0]   op_ext;

    bankpfx_capture u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .iw_valid   (iw_valid),
        .iw_data    (iw_data),
        .insn_valid (insn_valid),
        .sel_eff    (sel)
    );

    // Gather per-operand bank bits and fields; index 0 is A and index 1 is B.
    always_comb begin
        op_bank[0]  = sel.a_bank;
        op_bank[1]  = sel.b_bank;
        op_field[0] = op_a_field;
        op_field[1] = op_b_field;
    end

    for (genvar gi = 0; gi < 2; gi++) begin : g_operand
        bankpfx_extend #(.BANK_W(BANK_W), .FIELD_W(FIELD_W)) u_extend (
            .bank  (op_bank[gi]),
            .field (op_field[gi]),
            .idx   (op_ext[gi])
        );
    end

    // Drive the operand outputs.
    always_comb begin
        ext_a = op_ext[0];
        ext_b = op_ext[1];
    end

    bankpfx_dest #(.BANK_W(BANK_W), .FIELD_W(FIELD_W)) u_dest (
        .dst_bank (sel.dst_bank),
        .dst_mode (sel.dst_mode),
        .field_a  (op_a_field),
        .field_b  (op_b_field),
        .ext_b    (op_ext[1]),
        .ext_dst  (ext_dst),
        .override (dst_override)
    );

    bankpfx_ea #(.FIELD_W(FIELD_W)) u_ea (
        .ea_mode     (ea_mode),
        .base_hi     (sel.a_bank[0]),
        .index_hi    (sel.a_bank[1]),
        .idx_is_addr (idx_is_addr),
        .field_a     (op_a_field),
        .field_b     (op_b_field),
        .ea_base     (ea_base),
        .ea_index    (ea_index)
    );
endmodule

// File: rtl/bank_prefix_decoder_sva.sv
// Module: checker bound to the decoder; relates ports across cycles.
// Assumes iw_valid is low while reset is asserted.
module bank_prefix_decoder_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        iw_valid,
    input logic [15:0] iw_data,
    input logic [2:0]  op_a_field,
    input logic [2:0]  op_b_field,
    input logic        ea_mode,
    input logic        insn_valid,
    input logic [4:0]  ext_a,
    input logic [4:0]  ext_b,
    input logic [4:0]  ext_dst,
    input logic        dst_override,
    input logic [3:0]  ea_base,
    input logic [4:0]  ea_index
);
    p_prefix_not_insn_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (iw_valid && iw_data[15:8] == 8'h71) |-> !insn_valid);

    p_bank_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && $past(rst_n) && $past(iw_valid && iw_data[15:8] == 8'h71))
        |-> (ext_a[4:3] == $past(iw_data[3:2]) && ext_b[4:3] == $past(iw_data[1:0])));

    p_field_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid |-> (ext_a[2:0] == op_a_field && ext_b[2:0] == op_b_field));

    p_one_shot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && $past(rst_n) && $past(insn_valid))
        |-> (ext_a[4:3] == 2'b00 && ext_b[4:3] == 2'b00 && !dst_override));

    p_legacy_dst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && !dst_override) |-> ext_dst == ext_b);

    p_ea_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ea_mode |-> (ea_base == 4'd0 && ea_index == 5'd0));
endmodule

bind bank_prefix_decoder bank_prefix_decoder_sva u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .iw_valid     (iw_valid),
    .iw_data      (iw_data),
    .op_a_field   (op_a_field),
    .op_b_field   (op_b_field),
    .ea_mode      (ea_mode),
    .insn_valid   (insn_valid),
    .ext_a        (ext_a),
    .ext_b        (ext_b),
    .ext_dst      (ext_dst),
    .dst_override (dst_override),
    .ea_base      (ea_base),
    .ea_index     (ea_index)
);

// File: tb/bank_prefix_decoder_bench.sv
module bank_prefix_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iw_valid = 1'b0;
    logic [15:0] iw_data = 16'h0000;
    logic [2:0]  op_a_field = 3'd0;
    logic [2:0]  op_b_field = 3'd0;
    logic        ea_mode = 1'b0;
    logic        idx_is_addr = 1'b0;
    logic        insn_valid;
    logic [4:0]  ext_a, ext_b, ext_dst, ea_index;
    logic [3:0]  ea_base;
    logic        dst_override;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    localparam logic [15:0] PLAIN = 16'h2001;

    always #2 clk = ~clk;

    bank_prefix_decoder u_bank_prefix_decoder (
        .clk(clk), .rst_n(rst_n), .iw_valid(iw_valid), .iw_data(iw_data),
        .op_a_field(op_a_field), .op_b_field(op_b_field), .ea_mode(ea_mode),
        .idx_is_addr(idx_is_addr), .insn_valid(insn_valid), .ext_a(ext_a),
        .ext_b(ext_b), .ext_dst(ext_dst), .dst_override(dst_override),
        .ea_base(ea_base), .ea_index(ea_index)
    );

    typedef struct packed {
        logic        has_pfx;
        logic [15:0] pfx;
        logic [2:0]  a;
        logic [2:0]  b;
        logic        ea;
        logic        ia;
        logic [4:0]  xa;
        logic [4:0]  xb;
        logic [4:0]  xd;
        logic        xo;
        logic [3:0]  xbase;
        logic [4:0]  xidx;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 16'h0000, 3'd3, 3'd5, 1'b0, 1'b0, 5'd3,  5'd5,  5'd5,  1'b0, 4'd0,  5'd0},  // R5
        '{1'b1, 16'h7106, 3'd0, 3'd1, 1'b0, 1'b0, 5'd8,  5'd17, 5'd17, 1'b0, 4'd0,  5'd0},  // R13
        '{1'b1, 16'h71CD, 3'd2, 3'd7, 1'b0, 1'b0, 5'd26, 5'd15, 5'd15, 1'b0, 4'd0,  5'd0},  // R2 R3
        '{1'b1, 16'h7150, 3'd6, 3'd1, 1'b0, 1'b0, 5'd6,  5'd1,  5'd14, 1'b1, 4'd0,  5'd0},  // R7
        '{1'b1, 16'h71A7, 3'd4, 3'd2, 1'b0, 1'b0, 5'd12, 5'd26, 5'd18, 1'b1, 4'd0,  5'd0},  // R8
        '{1'b1, 16'h71F0, 3'd1, 3'd3, 1'b0, 1'b0, 5'd1,  5'd3,  5'd3,  1'b0, 4'd0,  5'd0},  // R9
        '{1'b1, 16'h7108, 3'd5, 3'd6, 1'b1, 1'b0, 5'd21, 5'd6,  5'd6,  1'b0, 4'd5,  5'd22}, // R10
        '{1'b1, 16'h7104, 3'd7, 3'd2, 1'b1, 1'b1, 5'd15, 5'd2,  5'd2,  1'b0, 4'd15, 5'd10}, // R10
        '{1'b0, 16'h0000, 3'd7, 3'd7, 1'b1, 1'b1, 5'd7,  5'd7,  5'd7,  1'b0, 4'd7,  5'd15}  // R10
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Present one word on the next falling edge.
    task automatic put(input logic v, input logic [15:0] w, input logic [2:0] a,
                       input logic [2:0] b, input logic ea, input logic ia);
        @(negedge clk);
        iw_valid = v; iw_data = w; op_a_field = a; op_b_field = b;
        ea_mode = ea; idx_is_addr = ia;
        #1;
    endtask

    task automatic all_out(input string req, input vec_t t);
        chk(req, {insn_valid, ext_a, ext_b, ext_dst, dst_override, ea_base, ea_index},
            {1'b1, t.xa, t.xb, t.xd, t.xo, t.xbase, t.xidx});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R11 reset insn_valid", {31'd0, insn_valid}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            if (TBL[i].has_pfx) begin
                put(1'b1, TBL[i].pfx, 3'd0, 3'd0, 1'b0, 1'b0);
                chk("R1 prefix hides insn_valid", {31'd0, insn_valid}, 32'd0);
            end
            put(1'b1, PLAIN, TBL[i].a, TBL[i].b, TBL[i].ea, TBL[i].ia);
            all_out($sformatf("R2/R3/R7-R10 vector %0d", i), TBL[i]);
        end

        // R1: near-miss tag is an instruction
        put(1'b1, 16'h7006, 3'd0, 3'd1, 1'b0, 1'b0);
        chk("R1 non-tag word", {27'd0, insn_valid, ext_a[4:3], ext_b[4:3]}, {27'd0, 1'b1, 4'b0000});

        // R4: one-shot, survives idle gap
        put(1'b1, 16'h710F, 3'd0, 3'd0, 1'b0, 1'b0);
        put(1'b0, PLAIN, 3'd0, 3'd0, 1'b0, 1'b0);
        put(1'b0, PLAIN, 3'd0, 3'd0, 1'b0, 1'b0);
        put(1'b1, PLAIN, 3'd1, 3'd2, 1'b0, 1'b0);
        chk("R4 after idle", {22'd0, ext_a, ext_b}, {22'd0, 5'd25, 5'd26});
        put(1'b1, PLAIN, 3'd1, 3'd2, 1'b0, 1'b0);
        chk("R4 second insn", {22'd0, ext_a, ext_b}, {22'd0, 5'd1, 5'd2});

        // R6: second prefix replaces first
        put(1'b1, 16'h71D7, 3'd0, 3'd0, 1'b0, 1'b0);
        put(1'b1, 16'h7108, 3'd0, 3'd0, 1'b0, 1'b0);
        put(1'b1, PLAIN, 3'd3, 3'd4, 1'b0, 1'b0);
        chk("R6 replaced", {16'd0, ext_a, ext_b, dst_override}, {16'd0, 5'd19, 5'd4, 1'b0});

        // R12: masked prefix word
        put(1'b0, 16'h710F, 3'd0, 3'd0, 1'b0, 1'b0);
        put(1'b1, PLAIN, 3'd5, 3'd6, 1'b0, 1'b0);
        chk("R12 masked prefix", {22'd0, ext_a, ext_b}, {22'd0, 5'd5, 5'd6});

        // R11: reset cancels pending prefix
        put(1'b1, 16'h715F, 3'd0, 3'd0, 1'b0, 1'b0);
        put(1'b0, PLAIN, 3'd0, 3'd0, 1'b0, 1'b0);
        rst_n = 1'b0;
        put(1'b0, PLAIN, 3'd0, 3'd0, 1'b0, 1'b0);
        rst_n = 1'b1;
        put(1'b1, PLAIN, 3'd2, 3'd3, 1'b0, 1'b0);
        chk("R11 prefix cleared", {21'd0, ext_a, ext_b, dst_override},
            {21'd0, 5'd2, 5'd3, 1'b0});

        put(1'b0, PLAIN, 3'd0, 3'd0, 1'b0, 1'b0);
        finish_run();
    end
endmodule